// File: doc/BRIEF.md
# Wake Interrupt Capture Controller

This block watches a bank of raw interrupt lines while the main interrupt controller is idle, for example during a low-power state. It latches every line that fires so software can replay the events once the main controller is running again. Lines are grouped 32 to a register word. Line `n` lives in group `n/32` at bit `n%32`, and every per-line bank uses that same layout. Each line has three settings: a mask, a sensitivity (edge or level) and a polarity (positive or negative). Each setting is changed through its own write-one-to-set word and write-one-to-clear word, and can be read back through a status word.

A control word holds a global enable, an edge-only override and a software reset that clears itself. Each group has an acknowledge word that clears pending latches one bit at a time. The recommended start-up sequence is to acknowledge every group and then write enable together with edge-only.

The register port is plain. A write presented with `bus_wen` is taken on that clock edge with no back-pressure, and reads are combinational from `bus_raddr`. A register address is `{bank[3:0], group}`. The bank codes are:

| Code | Bank |
|------|------|
| 0 | control |
| 1 | mask status |
| 2 | mask set |
| 3 | mask clear |
| 4 | sensitivity status |
| 5 | sensitivity set |
| 6 | sensitivity clear |
| 7 | polarity status |
| 8 | polarity set |
| 9 | polarity clear |
| 10 | pending status |
| 11 | acknowledge |

In the control word, bit 0 is enable, bit 1 is edge-only and bit 2 is soft reset.

Top module: `wake_irq_capture`

## Requirements
- R1: Line n maps to group n/32, bit n%32, in every bank. Mask set (code 2) and mask clear (code 3) change only the bits written as 1. Mask status (code 1) reads 1 for a masked line.
- R2: Sensitivity set (code 5) selects level and sensitivity clear (code 6) selects edge. Sensitivity status (code 4) reads 1 for level. Bits written as 0 leave their lines unchanged.
- R3: Polarity set (code 8) selects positive and polarity clear (code 9) selects negative. Polarity status (code 7) reads 1 for positive. Bits written as 0 leave their lines unchanged.
- R4: An edge-sensitive line sets its pending bit (code 10) on a rising input when positive, or on a falling input when negative, and only while it is enabled and unmasked. The pending bit is visible on the third clock edge after the input changes.
- R5: A level-sensitive line sets its pending bit while its input sits at the active level.
- R6: A pending bit stays set after the input returns inactive. A 1 written to the acknowledge word (code 11) clears that bit, and a 0 bit has no effect.
- R7: When an acknowledge and a detection fall on the same line in the same cycle, the pending bit stays set.
- R8: While edge-only (control bit 1) is set, level-sensitive lines are detected on their active edge only, so a line held active is not captured again after it is acknowledged.
- R9: With enable (control bit 0) clear, no new pending bit is set. Existing pending bits and the edge-only bit keep their values.
- R10: Writing soft reset (control bit 2) clears all pending bits and returns every line to masked, edge and negative. The soft reset bit then reads 0 again, while the enable bit written with it is kept.
- R11: After hardware reset, every line is masked, edge-sensitive and negative, no line is pending, and the control word reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NUM_GROUPS*32 | Raw interrupt lines, asynchronous |
| bus_wen | input | 1 | Register write strobe |
| bus_waddr | input | 4+GW | Write address {bank, group} |
| bus_wdata | input | 32 | Write data |
| bus_raddr | input | 4+GW | Read address {bank, group} |
| bus_rdata | output | 32 | Read data, combinational |

## Verification
The assertions assume the following about the block's inputs:
- The raw lines are quiet while reset is asserted.
- Polarity does not change on a line that is enabled and unmasked, because a polarity flip on a static input looks like an edge.
- No control write lands in the cycle in which a soft reset is being applied.

The stimulus respects these limits in three ways:
- It changes polarity only before capture is enabled.
- It issues each soft reset as a single isolated control write.
- It holds every line in each new state for several cycles before it reads the pending status, which keeps the two-flop synchronizer latency out of the comparison.

// File: rtl/wic_pkg.sv
package wic_pkg;
  typedef enum logic [3:0] {
    BK_CTRL     = 4'd0,
    BK_MASK_ST  = 4'd1,
    BK_MASK_SET = 4'd2,
    BK_MASK_CLR = 4'd3,
    BK_SENS_ST  = 4'd4,
    BK_SENS_SET = 4'd5,
    BK_SENS_CLR = 4'd6,
    BK_POL_ST   = 4'd7,
    BK_POL_SET  = 4'd8,
    BK_POL_CLR  = 4'd9,
    BK_PEND     = 4'd10,
    BK_ACK      = 4'd11
  } bank_e;

  localparam int CTL_EN   = 0;
  localparam int CTL_EDGE = 1;
  localparam int CTL_SRST = 2;
  localparam int WORD_W   = 32;
endpackage

// File: rtl/wic_cfg_regs.sv
module wic_cfg_regs
  import wic_pkg::*;
#(
  parameter int NUM_GROUPS = 2,
  localparam int NL = NUM_GROUPS * WORD_W,
  localparam int GW = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int AW = 4 + GW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wen,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  input  logic [NL-1:0]     pend,
  output logic [WORD_W-1:0] rdata,
  output logic [NL-1:0]     mask_q,
  output logic [NL-1:0]     sens_q,
  output logic [NL-1:0]     pol_q,
  output logic [NL-1:0]     ack,
  output logic              en_q,
  output logic              edge_only_q,
  output logic              srst_q
);
  bank_e          wbank, rbank;
  logic [GW-1:0]  wgrp, rgrp;

  assign wbank = bank_e'(waddr[AW-1 -: 4]);
  assign wgrp  = waddr[GW-1:0];
  assign rbank = bank_e'(raddr[AW-1 -: 4]);
  assign rgrp  = raddr[GW-1:0];

  // control word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q        <= 1'b0;
      edge_only_q <= 1'b0;
      srst_q      <= 1'b0;
    end else if (wen && wbank == BK_CTRL) begin
      en_q        <= wdata[CTL_EN];
      edge_only_q <= wdata[CTL_EDGE];
      srst_q      <= wdata[CTL_SRST];
    end else begin
      srst_q      <= 1'b0;
    end
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic sel;
    assign sel = wen && (wgrp == GW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q[g*WORD_W +: WORD_W] <= '1;
        sens_q[g*WORD_W +: WORD_W] <= '0;
        pol_q[g*WORD_W +: WORD_W]  <= '0;
      end else if (srst_q) begin
        mask_q[g*WORD_W +: WORD_W] <= '1;
        sens_q[g*WORD_W +: WORD_W] <= '0;
        pol_q[g*WORD_W +: WORD_W]  <= '0;
      end else if (sel) begin
        case (wbank)
          BK_MASK_SET: mask_q[g*WORD_W +: WORD_W] <= mask_q[g*WORD_W +: WORD_W] | wdata;
          BK_MASK_CLR: mask_q[g*WORD_W +: WORD_W] <= mask_q[g*WORD_W +: WORD_W] & ~wdata;
          BK_SENS_SET: sens_q[g*WORD_W +: WORD_W] <= sens_q[g*WORD_W +: WORD_W] | wdata;
          BK_SENS_CLR: sens_q[g*WORD_W +: WORD_W] <= sens_q[g*WORD_W +: WORD_W] & ~wdata;
          BK_POL_SET:  pol_q[g*WORD_W +: WORD_W]  <= pol_q[g*WORD_W +: WORD_W] | wdata;
          BK_POL_CLR:  pol_q[g*WORD_W +: WORD_W]  <= pol_q[g*WORD_W +: WORD_W] & ~wdata;
          default: ;
        endcase
      end
    end

    assign ack[g*WORD_W +: WORD_W] = (sel && wbank == BK_ACK) ? wdata : '0;
  end

  // read mux
  always_comb begin
    rdata = '0;
    if (int'(rgrp) < NUM_GROUPS) begin
      case (rbank)
        BK_CTRL:    rdata = {29'd0, srst_q, edge_only_q, en_q};
        BK_MASK_ST: rdata = mask_q[rgrp*WORD_W +: WORD_W];
        BK_SENS_ST: rdata = sens_q[rgrp*WORD_W +: WORD_W];
        BK_POL_ST:  rdata = pol_q[rgrp*WORD_W +: WORD_W];
        BK_PEND:    rdata = pend[rgrp*WORD_W +: WORD_W];
        default:    rdata = '0;
      endcase
    end
  end

  // R10
  srst_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> (mask_q == '1 && sens_q == '0 && pol_q == '0));

  // R10
  srst_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_q && !(wen && wbank == BK_CTRL)) |=> !srst_q);
endmodule

// File: rtl/wic_detect.sv
module wic_detect #(
  parameter int NL = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NL-1:0] irq_in,
  input  logic [NL-1:0] mask,
  input  logic [NL-1:0] sens,
  input  logic [NL-1:0] pol,
  input  logic          en,
  input  logic          edge_only,
  output logic [NL-1:0] hit
);
  logic [NL-1:0] s1_q, s2_q, prev_q;
  logic [NL-1:0] act, prev_act, use_level, det;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= irq_in;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign act       = ~(s2_q ^ pol);
  assign prev_act  = ~(prev_q ^ pol);
  assign use_level = sens & {NL{~edge_only}};
  assign det       = (use_level & act) | (~use_level & act & ~prev_act);
  assign hit       = det & ~mask & {NL{en}};

  // R4
  hit_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit & ~(s2_q ^ pol) ) == hit);
endmodule

// File: rtl/wic_pending.sv
module wic_pending #(
  parameter int NL = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          srst,
  input  logic [NL-1:0] hit,
  input  logic [NL-1:0] ack,
  output logic [NL-1:0] pend_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_q <= '0;
    else if (srst)   pend_q <= '0;
    else             pend_q <= (pend_q & ~ack) | hit;
  end

  // R6
  clear_only_by_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(srst) |-> (($past(pend_q) & ~pend_q & ~$past(ack)) == '0));

  // R7
  ack_hit_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(srst) |-> (($past(hit) & $past(ack) & ~pend_q) == '0));

  // R4
  set_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q) & ~$past(hit)) == '0));

  // R10
  srst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (pend_q == '0));
endmodule

// File: rtl/wake_irq_capture.sv
module wake_irq_capture
  import wic_pkg::*;
#(
  parameter int NUM_GROUPS = 2,
  localparam int NL = NUM_GROUPS * 32,
  localparam int GW = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int AW = 4 + GW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NL-1:0] irq_in,
  input  logic          bus_wen,
  input  logic [AW-1:0] bus_waddr,
  input  logic [31:0]   bus_wdata,
  input  logic [AW-1:0] bus_raddr,
  output logic [31:0]   bus_rdata
);
  logic [NL-1:0] mask, sens, pol, ack, hit, pend;
  logic          en, edge_only, srst;

  wic_cfg_regs #(.NUM_GROUPS(NUM_GROUPS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wen(bus_wen), .waddr(bus_waddr),
    .wdata(bus_wdata), .raddr(bus_raddr), .pend(pend), .rdata(bus_rdata),
    .mask_q(mask), .sens_q(sens), .pol_q(pol), .ack(ack),
    .en_q(en), .edge_only_q(edge_only), .srst_q(srst)
  );

  wic_detect #(.NL(NL)) u_det (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .mask(mask), .sens(sens),
    .pol(pol), .en(en), .edge_only(edge_only), .hit(hit)
  );

  wic_pending #(.NL(NL)) u_pend (
    .clk(clk), .rst_n(rst_n), .srst(srst), .hit(hit), .ack(ack),
    .pend_q(pend)
  );

  // R9
  no_capture_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> ((pend & ~$past(pend)) == '0));

  // R4
  no_capture_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~$past(pend) & $past(mask)) == '0));
endmodule

// File: tb/wake_irq_capture_bench.sv
`timescale 1ns/1ps
module wake_irq_capture_bench;
  localparam int G  = 2;
  localparam int NL = G * 32;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] irq = '0;
  logic          wen = 1'b0;
  logic [AW-1:0] waddr = '0;
  logic [31:0]   wdata = '0;
  logic [AW-1:0] raddr = '0;
  logic [31:0]   rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  wake_irq_capture #(.NUM_GROUPS(G)) u_wake_irq_capture (
    .clk(clk), .rst_n(rst_n), .irq_in(irq), .bus_wen(wen),
    .bus_waddr(waddr), .bus_wdata(wdata), .bus_raddr(raddr),
    .bus_rdata(rdata)
  );

  function automatic logic [AW-1:0] adr(input int bank, input int g);
    return {bank[3:0], g[0]};
  endfunction

  task automatic wr(input int bank, input int g, input logic [31:0] d);
    @(posedge clk); #1;
    wen = 1'b1; waddr = adr(bank, g); wdata = d;
    @(posedge clk); #1;
    wen = 1'b0;
  endtask

  // driver: pushes the expected word, monitor compares at the next falling edge
  task automatic chk(input int bank, input int g, input logic [31:0] e, input string tag);
    @(posedge clk); #1;
    raddr = adr(bank, g);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk); #1;
  endtask

  task automatic line(input int idx, input logic v);
    @(posedge clk); #1;
    irq[idx] = v;
    repeat (4) @(posedge clk);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (rdata !== e) begin
          fails++;
          $display("FAIL %s: got %h expected %h", t, rdata, e);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R11 reset state
    chk(1, 0, 32'hFFFF_FFFF, "R11 mask g0");
    chk(1, 1, 32'hFFFF_FFFF, "R11 mask g1");
    chk(4, 0, 32'h0, "R11 sens");
    chk(7, 1, 32'h0, "R11 pol");
    chk(10, 0, 32'h0, "R11 pend");
    chk(0, 0, 32'h0, "R11 ctrl");

    // R1 set/clear with untouched bits
    wr(3, 1, 32'h0000_00F0);
    chk(1, 1, 32'hFFFF_FF0F, "R1 mask clear");
    wr(2, 1, 32'h0000_0010);
    chk(1, 1, 32'hFFFF_FF1F, "R1 mask set");
    chk(1, 0, 32'hFFFF_FFFF, "R1 other group");

    // R2 sensitivity
    wr(5, 0, 32'h5);
    chk(4, 0, 32'h5, "R2 sens set");
    wr(6, 0, 32'h1);
    chk(4, 0, 32'h4, "R2 sens clear");

    // R3 polarity
    wr(8, 1, 32'h30);
    chk(7, 1, 32'h30, "R3 pol set");
    wr(9, 1, 32'h20);
    chk(7, 1, 32'h10, "R3 pol clear");

    // working setup: all unmasked, edge, lines 0-3 positive
    wr(3, 0, 32'hFFFF_FFFF);
    wr(3, 1, 32'hFFFF_FFFF);
    wr(6, 0, 32'hFFFF_FFFF);
    wr(9, 0, 32'hFFFF_FFFF);
    wr(8, 0, 32'h0000_000F);

    // R9: disabled, no capture
    line(0, 1'b1);
    chk(10, 0, 32'h0, "R9 disabled no capture");
    line(0, 1'b0);

    // enable sequence
    wr(11, 0, 32'hFFFF_FFFF);
    wr(11, 1, 32'hFFFF_FFFF);
    wr(0, 0, 32'h1);
    chk(0, 0, 32'h1, "R9 enable reads back");

    // R4 edges
    line(0, 1'b1);
    chk(10, 0, 32'h1, "R4 rising positive");
    line(0, 1'b0);
    chk(10, 0, 32'h1, "R6 sticky after input low");
    line(4, 1'b1);
    chk(10, 0, 32'h1, "R4 rising negative ignored");
    line(4, 1'b0);
    chk(10, 0, 32'h11, "R4 falling negative");
    wr(2, 0, 32'h100);
    line(8, 1'b1);
    line(8, 1'b0);
    chk(10, 0, 32'h11, "R4 masked line ignored");

    // R6 acknowledge
    wr(11, 0, 32'h1);
    chk(10, 0, 32'h10, "R6 ack clears bit");
    wr(11, 0, 32'h0);
    chk(10, 0, 32'h10, "R6 zero ack no effect");
    wr(11, 0, 32'h10);
    chk(10, 0, 32'h0, "R6 ack second bit");

    // R5 level
    wr(5, 0, 32'h2);
    line(1, 1'b1);
    chk(10, 0, 32'h2, "R5 level capture");
    // R7 ack while detection continues
    wr(11, 0, 32'h2);
    chk(10, 0, 32'h2, "R7 ack with simultaneous hit keeps bit");
    line(1, 1'b0);
    wr(11, 0, 32'h2);
    chk(10, 0, 32'h0, "R6 ack after level drops");

    // R8 edge-only override
    wr(0, 0, 32'h3);
    chk(0, 0, 32'h3, "R8 ctrl edge-only");
    line(1, 1'b1);
    chk(10, 0, 32'h2, "R8 edge capture of level line");
    wr(11, 0, 32'h2);
    repeat (3) @(posedge clk);
    chk(10, 0, 32'h0, "R8 no recapture while held");
    line(1, 1'b0);

    // R9 disable keeps state
    line(3, 1'b1);
    chk(10, 0, 32'h8, "R4 line 3 rising");
    wr(0, 0, 32'h2);
    chk(0, 0, 32'h2, "R9 edge-only kept");
    chk(10, 0, 32'h8, "R9 pending kept");
    line(2, 1'b1);
    chk(10, 0, 32'h8, "R9 no new capture");

    // R10 soft reset
    wr(0, 0, 32'h5);
    repeat (2) @(posedge clk);
    chk(0, 0, 32'h1, "R10 self clear keeps enable");
    chk(10, 0, 32'h0, "R10 pending cleared");
    chk(1, 0, 32'hFFFF_FFFF, "R10 mask g0");
    chk(1, 1, 32'hFFFF_FFFF, "R10 mask g1");
    chk(4, 0, 32'h0, "R10 sens");
    chk(7, 0, 32'h0, "R10 pol");

    // R1 highest line in group 1
    line(2, 1'b0);
    line(3, 1'b0);
    wr(3, 1, 32'h8000_0000);
    chk(1, 1, 32'h7FFF_FFFF, "R1 line 63 unmasked");
    line(63, 1'b1);
    chk(10, 1, 32'h0, "R4 line 63 rising ignored");
    line(63, 1'b0);
    chk(10, 1, 32'h8000_0000, "R1 line 63 pending bit 31 group 1");
    chk(10, 0, 32'h0, "R1 group 0 untouched");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule